// File: doc/BRIEF.md
# Multi-Cycle Restoring Integer Divider

This block divides one integer by another over several clock cycles. It supports both unsigned and two's-complement operands. It keeps one combined working register. The upper half of that register holds the partial remainder and the lower half collects quotient bits as they are produced. A single subtractor, of operand width plus one bit, serves every step. For signed work the operands are first reduced to magnitudes, the unsigned core runs, and the signs of the results are restored at the end.

The host presents the dividend, the divisor and a signedness flag together with a one-cycle start pulse. A start pulse is only taken while the block is idle. A run first shifts the working register left once. It then performs one subtract-and-shift step per quotient bit. A last cycle moves only the remainder half back right by one place, because the initial shift leaves it one position too high. The quotient and remainder are then latched onto the outputs and a one-cycle completion pulse is raised. A zero divisor skips all iterations: completion is reported in the next cycle with the zero-divisor flag set.

Top module: `seq_restoring_div`

## Requirements
- R1: After reset, `done_o` and `dz_o` are 0 and `quo_o` and `rem_o` are all zeros.
- R2: With `signed_i` = 0, `quo_o` equals floor(dividend / divisor) and `rem_o` equals dividend mod divisor, with both operands read as unsigned.
- R3: With `signed_i` = 1, both operands are read as two's complement. `quo_o` is the true quotient truncated toward zero, so it is negative exactly when the operand signs differ and the magnitude quotient is nonzero.
- R4: With `signed_i` = 1, `rem_o` carries the sign of the dividend and satisfies dividend = quotient * divisor + remainder. For example, -7 / 2 gives quotient -3 and remainder -1.
- R5: For a nonzero divisor, `done_o` is high in the cycle that follows the WIDTH+2-th rising edge after the edge that accepted `start_i`.
- R6: `done_o` stays high for a single cycle unless a new operation completes right after it.
- R7: A `start_i` pulse that arrives while a division is running is ignored. The running operation's results, latency and flag are unchanged, and no extra completion follows.
- R8: A zero divisor raises `done_o` and `dz_o` together one cycle after acceptance. `dz_o` is 0 on every completion with a nonzero divisor.
- R9: `quo_o` and `rem_o` hold their values between completions.
- R10: Signed division of the most negative value by -1 yields quotient equal to the most negative value (wrapped) and remainder 0.
- R11: A `start_i` presented during the cycle in which `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a division |
| signed_i | input | 1 | 1 selects two's-complement operands |
| dividend_i | input | WIDTH | Dividend, sampled with start_i |
| divisor_i | input | WIDTH | Divisor, sampled with start_i |
| quo_o | output | WIDTH | Quotient of the last completed division |
| rem_o | output | WIDTH | Remainder of the last completed division |
| done_o | output | 1 | One-cycle completion pulse |
| dz_o | output | 1 | Zero-divisor indication, valid with done_o |

## Verification
Two functions can meet in one cycle. One is the completion pulse of a finished division. The other is the acceptance of a fresh start request, either one that arrives while the block is busy or one that arrives in the very cycle the pulse is raised. The bench provokes the first case by pulsing start with a zero divisor in the middle of a run, and judges that the run's results, latency and cleared flag are untouched and that no second pulse follows. It provokes the second case by driving start in the pulse cycle, and judges that the new operation finishes with full latency and correct results. An exhaustive sweep over every operand pair in both signedness modes, at a 5-bit width, checks the arithmetic against values computed in the bench.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ALIGN = 2'd1,
      ST_LOOP  = 2'd2,
      ST_FIX   = 2'd3
   } div_state_e;
endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep #(
   parameter int WIDTH     = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [WIDTH-1:0] dividend_i,
   input  logic [WIDTH-1:0] divisor_i,
   input  logic             signed_i,
   output logic [WIDTH-1:0] mag_a_o,
   output logic [WIDTH-1:0] mag_b_o,
   output logic             neg_q_o,
   output logic             neg_r_o
);
   generate
      if (SIGNED_EN) begin : g_signed
         logic neg_a;
         logic neg_b;
         assign neg_a   = signed_i & dividend_i[WIDTH-1];
         assign neg_b   = signed_i & divisor_i[WIDTH-1];
         // Magnitude of the most negative value fits as unsigned WIDTH bits
         assign mag_a_o = neg_a ? (~dividend_i + 1'b1) : dividend_i;
         assign mag_b_o = neg_b ? (~divisor_i + 1'b1) : divisor_i;
         assign neg_q_o = neg_a ^ neg_b;
         assign neg_r_o = neg_a;
      end else begin : g_unsigned
         logic unused_signed;
         assign unused_signed = signed_i;
         assign mag_a_o = dividend_i;
         assign mag_b_o = divisor_i;
         assign neg_q_o = 1'b0;
         assign neg_r_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/div_step.sv
module div_step #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH:0]   hi_i,
   input  logic [WIDTH-1:0] lo_i,
   input  logic [WIDTH-1:0] dvsr_i,
   output logic [WIDTH:0]   hi_o,
   output logic [WIDTH-1:0] lo_o,
   output logic             qbit_o
);
   localparam int DW = WIDTH + 2;

   logic [DW-1:0]    diff;
   logic             below;
   logic [WIDTH-1:0] kept;

   // One subtract over the widened partial remainder
   assign diff   = {1'b0, hi_i} - {2'b00, dvsr_i};
   assign below  = diff[DW-1];
   // Restore by selecting the unmodified value when the difference went negative
   assign kept   = below ? hi_i[WIDTH-1:0] : diff[WIDTH-1:0];
   assign qbit_o = ~below;
   // Shift the whole register left, the quotient bit entering at the bottom
   assign hi_o   = {kept, lo_i[WIDTH-1]};
   assign lo_o   = {lo_i[WIDTH-2:0], qbit_o};
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
   parameter int WIDTH     = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [WIDTH-1:0] qmag_i,
   input  logic [WIDTH-1:0] rmag_i,
   input  logic             neg_q_i,
   input  logic             neg_r_i,
   output logic [WIDTH-1:0] quo_o,
   output logic [WIDTH-1:0] rem_o
);
   generate
      if (SIGNED_EN) begin : g_fix
         assign quo_o = neg_q_i ? (~qmag_i + 1'b1) : qmag_i;
         assign rem_o = neg_r_i ? (~rmag_i + 1'b1) : rmag_i;
      end else begin : g_pass
         logic unused_flags;
         assign unused_flags = neg_q_i | neg_r_i;
         assign quo_o = qmag_i;
         assign rem_o = rmag_i;
      end
   endgenerate
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div
   import div_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             signed_i,
   input  logic [WIDTH-1:0] dividend_i,
   input  logic [WIDTH-1:0] divisor_i,
   output logic [WIDTH-1:0] quo_o,
   output logic [WIDTH-1:0] rem_o,
   output logic             done_o,
   output logic             dz_o
);
   localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seq_restoring_div: WIDTH must be at least 2");
      end
   endgenerate

   div_state_e       state_q;
   logic [WIDTH:0]   hi_q;
   logic [WIDTH-1:0] lo_q;
   logic [WIDTH-1:0] dvsr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             neg_q_q;
   logic             neg_r_q;
   logic [WIDTH-1:0] quo_q;
   logic [WIDTH-1:0] rem_q;
   logic             done_q;
   logic             dz_q;

   logic [WIDTH-1:0] mag_a;
   logic [WIDTH-1:0] mag_b;
   logic             neg_q_in;
   logic             neg_r_in;
   logic [WIDTH:0]   hi_step;
   logic [WIDTH-1:0] lo_step;
   logic             qbit;
   logic [WIDTH-1:0] quo_fix;
   logic [WIDTH-1:0] rem_fix;

   div_sign_prep #(.WIDTH(WIDTH), .SIGNED_EN(SIGNED_EN)) u_prep (
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .signed_i   (signed_i),
      .mag_a_o    (mag_a),
      .mag_b_o    (mag_b),
      .neg_q_o    (neg_q_in),
      .neg_r_o    (neg_r_in)
   );

   div_step #(.WIDTH(WIDTH)) u_step (
      .hi_i   (hi_q),
      .lo_i   (lo_q),
      .dvsr_i (dvsr_q),
      .hi_o   (hi_step),
      .lo_o   (lo_step),
      .qbit_o (qbit)
   );

   // Correction: only the remainder half moves back right by one
   div_sign_fix #(.WIDTH(WIDTH), .SIGNED_EN(SIGNED_EN)) u_fix (
      .qmag_i  (lo_q),
      .rmag_i  (hi_q[WIDTH:1]),
      .neg_q_i (neg_q_q),
      .neg_r_i (neg_r_q),
      .quo_o   (quo_fix),
      .rem_o   (rem_fix)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hi_q    <= '0;
         lo_q    <= '0;
         dvsr_q  <= '0;
         cnt_q   <= '0;
         neg_q_q <= 1'b0;
         neg_r_q <= 1'b0;
         quo_q   <= '0;
         rem_q   <= '0;
         done_q  <= 1'b0;
         dz_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         dz_q   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (divisor_i == '0) begin
                     done_q <= 1'b1;
                     dz_q   <= 1'b1;
                  end else begin
                     hi_q    <= '0;
                     lo_q    <= mag_a;
                     dvsr_q  <= mag_b;
                     neg_q_q <= neg_q_in;
                     neg_r_q <= neg_r_in;
                     cnt_q   <= '0;
                     state_q <= ST_ALIGN;
                  end
               end
            end
            ST_ALIGN: begin
               hi_q    <= {hi_q[WIDTH-1:0], lo_q[WIDTH-1]};
               lo_q    <= {lo_q[WIDTH-2:0], 1'b0};
               state_q <= ST_LOOP;
            end
            ST_LOOP: begin
               hi_q  <= hi_step;
               lo_q  <= lo_step;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) begin
                  state_q <= ST_FIX;
               end
            end
            ST_FIX: begin
               quo_q   <= quo_fix;
               rem_q   <= rem_fix;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign quo_o  = quo_q;
   assign rem_o  = rem_q;
   assign done_o = done_q;
   assign dz_o   = dz_q;

   // R6: completion is only reported from the idle state
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> state_q == ST_IDLE);

   // R8: the zero-divisor flag never appears without completion
   p_dz_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dz_o |-> done_o);

   // R7: operands captured at acceptance stay fixed while busy
   p_busy_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && $past(state_q) != ST_IDLE)
         |-> ($stable(dvsr_q) && $stable(neg_q_q) && $stable(neg_r_q)));

   // R2: the partial remainder entering a step is below twice the divisor
   p_partial_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_LOOP |-> hi_q < {dvsr_q, 1'b0});

   // R5: the correction cycle follows the last iteration
   p_fix_after_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_FIX |-> ($past(state_q) == ST_LOOP && $past(cnt_q) == LAST));

   // R5: the iteration counter stays in range
   p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_LOOP |-> cnt_q <= LAST);

   // R9: results only change on completion
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(quo_o) && $stable(rem_o)));
endmodule

// File: tb/seq_restoring_div_tb.sv
module seq_restoring_div_tb;
   localparam int W = 5;
   localparam int LAT = W + 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         sgn = 1'b0;
   logic [W-1:0] a_i = '0;
   logic [W-1:0] b_i = '0;
   logic [W-1:0] quo;
   logic [W-1:0] rem;
   logic         done;
   logic         dz;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   seq_restoring_div #(.WIDTH(W), .SIGNED_EN(1'b1)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .signed_i   (sgn),
      .dividend_i (a_i),
      .divisor_i  (b_i),
      .quo_o      (quo),
      .rem_o      (rem),
      .done_o     (done),
      .dz_o       (dz)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
      @(negedge clk);
      start = 1'b1; a_i = a; b_i = b; sgn = s;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(inout int cyc);
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   function automatic int sx(input logic [W-1:0] v);
      return v[W-1] ? int'(v) - (1 << W) : int'(v);
   endfunction

   initial begin
      while (cycles < 200000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(done == 1'b0, "R1 done", int'(done), 0);
      chk(dz == 1'b0, "R1 dz", int'(dz), 0);
      chk(quo == '0, "R1 quo", int'(quo), 0);
      chk(rem == '0, "R1 rem", int'(rem), 0);

      // Exhaustive sweep, both modes
      for (int s = 0; s < 2; s++) begin
         for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
               int cyc;
               int eq, er;
               issue(W'(a), W'(b), s[0]);
               cyc = 1;
               wait_done(cyc);
               if (b == 0) begin
                  chk(cyc == 1, "R8 latency", cyc, 1);
                  chk(dz == 1'b1, "R8 dz", int'(dz), 1);
               end else begin
                  chk(cyc == LAT, "R5 latency", cyc, LAT);
                  chk(dz == 1'b0, "R8 dz clear", int'(dz), 0);
                  if (s == 0) begin
                     eq = a / b; er = a % b;
                     chk(quo == W'(eq), "R2 quotient", int'(quo), eq & ((1 << W) - 1));
                     chk(rem == W'(er), "R2 remainder", int'(rem), er);
                  end else begin
                     eq = sx(W'(a)) / sx(W'(b));
                     er = sx(W'(a)) % sx(W'(b));
                     if (a == (1 << (W - 1)) && b == (1 << W) - 1) begin
                        // R10 wrap of most negative / -1
                        chk(quo == W'(a), "R10 quotient", int'(quo), a);
                        chk(rem == '0, "R10 remainder", int'(rem), 0);
                     end else begin
                        chk(quo == W'(eq), "R3 quotient", sx(quo), eq);
                        chk(rem == W'(er), "R4 remainder", sx(rem), er);
                     end
                  end
               end
               @(negedge clk);
               chk(done == 1'b0, "R6 pulse", int'(done), 0);
            end
         end
      end

      // R4 explicit example: -7 / 2
      begin
         int cyc;
         issue(W'(-7), W'(2), 1'b1);
         cyc = 1;
         wait_done(cyc);
         chk(sx(quo) == -3, "R4 example quotient", sx(quo), -3);
         chk(sx(rem) == -1, "R4 example remainder", sx(rem), -1);
      end

      // R7 start while busy is ignored
      begin
         int cyc;
         issue(W'(27), W'(4), 1'b0);
         cyc = 1;
         repeat (2) begin @(negedge clk); cyc++; end
         start = 1'b1; a_i = W'(5); b_i = '0; sgn = 1'b0;
         @(negedge clk); cyc++;
         start = 1'b0;
         wait_done(cyc);
         chk(cyc == LAT, "R7 latency", cyc, LAT);
         chk(quo == W'(6), "R7 quotient", int'(quo), 6);
         chk(rem == W'(3), "R7 remainder", int'(rem), 3);
         chk(dz == 1'b0, "R7 dz", int'(dz), 0);
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(done == 1'b0, "R7 no extra done", int'(done), 0);
         end
         // R9 results held after completion
         chk(quo == W'(6), "R9 hold quotient", int'(quo), 6);
         chk(rem == W'(3), "R9 hold remainder", int'(rem), 3);
      end

      // R11 start accepted in the done cycle
      begin
         int cyc;
         issue(W'(20), W'(3), 1'b0);
         cyc = 1;
         wait_done(cyc);
         chk(done == 1'b1, "R11 first done", int'(done), 1);
         start = 1'b1; a_i = W'(29); b_i = W'(5); sgn = 1'b0;
         @(negedge clk);
         start = 1'b0;
         cyc = 1;
         wait_done(cyc);
         chk(cyc == LAT, "R11 latency", cyc, LAT);
         chk(quo == W'(5), "R11 quotient", int'(quo), 5);
         chk(rem == W'(4), "R11 remainder", int'(rem), 4);
      end

      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule